// File: doc/BRIEF.md
# I/O Address Descriptor Router

This block decides which downstream port receives an I/O request. Each request carries a 32-bit address, a read/write indicator and a special-cycle flag. The request is compared in parallel against a small bank of programmable descriptors of two kinds.

The first kind is a base/mask window. The request's upper address bits are masked and then compared with a base value. The special-cycle flag is compared against a stored bit, so it behaves as one more address bit. The second kind covers a fixed-size address range split into sixteen chunks. Each chunk has separate read and write enable bits, so that kind of descriptor can cut holes into the I/O map.

The address is never translated: it is forwarded unchanged next to the chosen destination ID. A request that matches no descriptor goes to a subtractive port whose ID is fixed by a parameter. Overlapping hits are resolved by a fixed priority and are flagged. Descriptors are loaded one whole 64-bit word at a time through a write-only register port.

Top module: `io_route_core`

## Requirements
- R1: The response address `rsp_addr` equals the request address of the request that produced the response; no bit is altered.
- R2: A request that hits no descriptor returns `rsp_subtr`=1 and `rsp_dest` equal to parameter `SUB_ID` (default 7).
- R3: A base/mask descriptor matches when (request address bits [31:12] AND descriptor bits [19:0]) equals descriptor bits [39:20].
- R4: A base/mask descriptor also requires the request's special-cycle flag to equal descriptor bit [60]. A special cycle is a write with the flag set; address 0 is shutdown, 1 is halt and 2 is the architecture-specific cycle, and all three route like any other flagged address.
- R5: When a descriptor of either kind wins, `rsp_dest` is that descriptor's bits [63:61] and `rsp_subtr` is 0.
- R6: A holes descriptor matches when request address bits [31:18] equal descriptor bits [13:0] and the enable bit picked by address bits [17:14] is 1. For writes that bit comes from the write-enable field, descriptor bits [47:32]; for reads it comes from the read-enable field, descriptor bits [31:16].
- R7: Descriptor slots are numbered with the base/mask descriptors first (slots 0 and 1) and the holes descriptors after them (slots 2 and 3). When several slots match, the lowest-numbered one wins and `rsp_multi` is 1; otherwise `rsp_multi` is 0.
- R8: After reset `rsp_valid` is 0 and no descriptor matches any request. The base/mask descriptors hold base field all ones with mask zero, and the holes descriptors hold all zeros.
- R9: `rsp_valid` is 1 exactly in the cycle after `req_valid` was 1, with the response fields registered at that edge. A descriptor write (`cfg_we`, slot `cfg_sel`, full word `cfg_wdata`) applies to requests from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor slot to write (base/mask first, then holes) |
| cfg_wdata | input | 64 | Full descriptor word |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request I/O address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spc | input | 1 | Special-cycle flag |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_dest | output | 3 | Destination port ID |
| rsp_addr | output | 32 | Device address (request address, untranslated) |
| rsp_subtr | output | 1 | Request routed to the subtractive port |
| rsp_multi | output | 1 | More than one descriptor matched |

## Verification
Directed vectors aim at each side of every comparison. Addresses just inside and just outside a masked window separate a mask error from a base error. Flipping the special-cycle flag on an otherwise matching address shows that the flag is compared like an address bit. Read and write requests to the same chunk separate the two enable fields, and a pair of overlapping holes descriptors shows the priority order and the multi-hit flag. Random vectors are drawn mostly near programmed bases with random don't-care bits, and the descriptors are reprogrammed at intervals, so that hits, misses and overlaps all occur in volume.

// File: rtl/iort_pkg.sv
package iort_pkg;

  localparam int DESC_W = 64;
  localparam int ID_W   = 3;

  typedef logic [DESC_W-1:0] desc_t;

  // Reset image of a base/mask slot: base all ones, mask zero => never equal
  localparam desc_t BM_RESET = {24'h0, 20'hFFFFF, 20'h0};

  function automatic logic bm_match(desc_t d, logic [31:0] a, logic spc);
    logic [19:0] masked;
    masked = a[31:12] & d[19:0];
    return (masked == d[39:20]) && (spc == d[60]);
  endfunction

  function automatic logic hl_match(desc_t d, logic [31:0] a, logic wr);
    logic [15:0] en;
    en = wr ? d[47:32] : d[31:16];
    return (a[31:18] == d[13:0]) && en[a[17:14]];
  endfunction

  function automatic logic [ID_W-1:0] dest_of(desc_t d);
    return d[63:61];
  endfunction

endpackage

// File: rtl/iort_desc_bank.sv
module iort_desc_bank #(
  parameter int NUM_BM = 2,
  parameter int NUM_HL = 2,
  localparam int NUM   = NUM_BM + NUM_HL,
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  iort_pkg::desc_t            cfg_wdata,
  output iort_pkg::desc_t [NUM-1:0]  descs
);

  for (genvar i = 0; i < NUM; i++) begin : g_slot
    localparam iort_pkg::desc_t RST = (i < NUM_BM) ? iort_pkg::BM_RESET : '0;
    iort_pkg::desc_t slot_q;
    logic            slot_wr;
    assign slot_wr = cfg_we && (cfg_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= RST;
      else if (slot_wr) slot_q <= cfg_wdata;
    end
    assign descs[i] = slot_q;
  end

endmodule

// File: rtl/iort_bm_match.sv
module iort_bm_match #(
  parameter int N = 2
) (
  input  iort_pkg::desc_t [N-1:0]                  descs,
  input  logic [31:0]                              addr,
  input  logic                                     spc,
  output logic [N-1:0]                             hit,
  output logic [N-1:0][iort_pkg::ID_W-1:0]         dest
);

  for (genvar i = 0; i < N; i++) begin : g_bm
    assign hit[i]  = iort_pkg::bm_match(descs[i], addr, spc);
    assign dest[i] = iort_pkg::dest_of(descs[i]);
    logic unused_fill;
    assign unused_fill = ^descs[i][59:40];
  end

  logic unused_low;
  assign unused_low = ^addr[11:0];

endmodule

// File: rtl/iort_hl_match.sv
module iort_hl_match #(
  parameter int N = 2
) (
  input  iort_pkg::desc_t [N-1:0]                  descs,
  input  logic [31:0]                              addr,
  input  logic                                     wr,
  output logic [N-1:0]                             hit,
  output logic [N-1:0][iort_pkg::ID_W-1:0]         dest
);

  for (genvar i = 0; i < N; i++) begin : g_hl
    assign hit[i]  = iort_pkg::hl_match(descs[i], addr, wr);
    assign dest[i] = iort_pkg::dest_of(descs[i]);
    logic unused_fill;
    assign unused_fill = ^{descs[i][60:48], descs[i][15:14]};
  end

  logic unused_low;
  assign unused_low = ^addr[13:0];

endmodule

// File: rtl/iort_pick.sv
module iort_pick #(
  parameter int N = 4,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]                       hits,
  input  logic [N-1:0][iort_pkg::ID_W-1:0]   dests,
  output logic                               any,
  output logic                               multi,
  output logic [SEL_W-1:0]                   idx,
  output logic [iort_pkg::ID_W-1:0]          dest
);

  int cnt;

  always_comb begin
    idx = '0;
    any = 1'b0;
    cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (hits[i]) begin
        cnt = cnt + 1;
        if (!any) begin
          any = 1'b1;
          idx = SEL_W'(i);
        end
      end
    end
    multi = (cnt > 1);
  end

  assign dest = dests[idx];

endmodule

// File: rtl/io_route_core.sv
module io_route_core #(
  parameter int                          NUM_BM = 2,
  parameter int                          NUM_HL = 2,
  parameter logic [iort_pkg::ID_W-1:0]   SUB_ID = 3'd7,
  localparam int NUM   = NUM_BM + NUM_HL,
  localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SEL_W-1:0]           cfg_sel,
  input  logic [63:0]                cfg_wdata,
  input  logic                       req_valid,
  input  logic [31:0]                req_addr,
  input  logic                       req_write,
  input  logic                       req_spc,
  output logic                       rsp_valid,
  output logic [iort_pkg::ID_W-1:0]  rsp_dest,
  output logic [31:0]                rsp_addr,
  output logic                       rsp_subtr,
  output logic                       rsp_multi
);

  iort_pkg::desc_t [NUM-1:0]                 descs;
  logic [NUM_BM-1:0]                         bm_hit;
  logic [NUM_BM-1:0][iort_pkg::ID_W-1:0]     bm_dest;
  logic [NUM_HL-1:0]                         hl_hit;
  logic [NUM_HL-1:0][iort_pkg::ID_W-1:0]     hl_dest;
  logic [NUM-1:0]                            hit_all;
  logic [NUM-1:0][iort_pkg::ID_W-1:0]        dest_all;
  logic                                      pick_any;
  logic                                      pick_multi;
  logic [SEL_W-1:0]                          pick_idx;
  logic [iort_pkg::ID_W-1:0]                 pick_dest;
  logic [iort_pkg::ID_W-1:0]                 route_dest;

  iort_desc_bank #(.NUM_BM(NUM_BM), .NUM_HL(NUM_HL)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .descs(descs)
  );

  iort_bm_match #(.N(NUM_BM)) u_bm (
    .descs(descs[NUM_BM-1:0]), .addr(req_addr), .spc(req_spc),
    .hit(bm_hit), .dest(bm_dest)
  );

  iort_hl_match #(.N(NUM_HL)) u_hl (
    .descs(descs[NUM-1:NUM_BM]), .addr(req_addr), .wr(req_write),
    .hit(hl_hit), .dest(hl_dest)
  );

  // base/mask slots take the low indices, so they win ties
  assign hit_all  = {hl_hit, bm_hit};
  assign dest_all = {hl_dest, bm_dest};

  iort_pick #(.N(NUM)) u_pick (
    .hits(hit_all), .dests(dest_all), .any(pick_any), .multi(pick_multi),
    .idx(pick_idx), .dest(pick_dest)
  );

  assign route_dest = pick_any ? pick_dest : SUB_ID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_dest  <= '0;
      rsp_addr  <= '0;
      rsp_subtr <= 1'b0;
      rsp_multi <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_dest  <= route_dest;
        rsp_addr  <= req_addr;
        rsp_subtr <= !pick_any;
        rsp_multi <= pick_multi;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr == $past(req_addr)); // R1

  AST_SUB_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_subtr) |-> rsp_dest == SUB_ID); // R2

  AST_MISS_SUBTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pick_any) |=> rsp_subtr); // R2

  AST_PICK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> hit_all[pick_idx]); // R7

  AST_MULTI_NOT_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> !rsp_subtr); // R7

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9

  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9

  for (genvar k = 0; k < NUM_BM; k++) begin : g_spc_chk
    AST_SPC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      bm_hit[k] |-> req_spc == descs[k][60]); // R4
  end

endmodule

// File: tb/io_route_core_tb.sv
module io_route_core_tb;

  localparam logic [2:0] EXP_SUB = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_spc = 1'b0;
  logic        rsp_valid;
  logic [2:0]  rsp_dest;
  logic [31:0] rsp_addr;
  logic        rsp_subtr;
  logic        rsp_multi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] mdl [4];

  always #5 clk = ~clk;

  io_route_core u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_spc(req_spc), .rsp_valid(rsp_valid),
    .rsp_dest(rsp_dest), .rsp_addr(rsp_addr), .rsp_subtr(rsp_subtr),
    .rsp_multi(rsp_multi)
  );

  // Reference: scan slots 0..3, first match wins, count matches
  task automatic model(input logic [31:0] a, input logic w, input logic s,
                       output logic [2:0] d, output logic sub, output logic mul);
    int n;
    n = 0; d = EXP_SUB; sub = 1'b1; mul = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic h;
      logic [15:0] f;
      if (k < 2) begin
        h = ((((a >> 12) & {12'h0, mdl[k][19:0]}) ^ {12'h0, mdl[k][39:20]}) == 32'h0)
            && (s == mdl[k][60]);
      end else begin
        f = w ? mdl[k][47:32] : mdl[k][31:16];
        h = ((a >> 18) == {18'h0, mdl[k][13:0]}) && (((f >> a[17:14]) & 16'd1) != 16'd0);
      end
      if (h) begin
        if (n == 0) begin d = mdl[k][63:61]; sub = 1'b0; end
        n++;
      end
    end
    mul = (n > 1);
  endtask

  task automatic wr_desc(input int idx, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(idx); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = $urandom;
    mdl[idx] = data;
  endtask

  task automatic send(input logic [31:0] a, input logic w, input logic s, input string tag);
    logic [2:0] ed;
    logic es, em;
    model(a, w, s, ed, es, em);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_spc = s;
    @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom; req_write = $urandom; req_spc = $urandom;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_dest !== ed || rsp_subtr !== es ||
        rsp_multi !== em || rsp_addr !== a) begin
      fails++;
      $display("FAIL %s: got v=%b d=%0d sub=%b multi=%b addr=%h exp v=1 d=%0d sub=%b multi=%b addr=%h",
               tag, rsp_valid, rsp_dest, rsp_subtr, rsp_multi, rsp_addr, ed, es, em, a);
    end
  endtask

  task automatic chk_idle(input string tag);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: got rsp_valid=%b exp 0", tag, rsp_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R9: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F0A_5EED));
    mdl[0] = {24'h0, 20'hFFFFF, 20'h0};
    mdl[1] = {24'h0, 20'hFFFFF, 20'h0};
    mdl[2] = '0;
    mdl[3] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state and no matches
    chk_idle("R8 reset rsp_valid");
    send(32'h0000_0000, 1'b0, 1'b0, "R8 addr 0 after reset");
    send(32'hFFFF_FFFF, 1'b1, 1'b1, "R8 all ones after reset");
    send(32'h0004_0000, 1'b1, 1'b0, "R8 holes slot cleared");
    chk_idle("R9 valid drops after request");

    // R3/R5: slot 0 window 0x0001_xxxx, flag 0, dest 2
    wr_desc(0, {3'd2, 1'b0, 20'h0, 20'h00010, 20'hFFFF0});
    send(32'h0001_2345, 1'b0, 1'b0, "R3 R5 inside window");
    send(32'h0001_FFFF, 1'b1, 1'b0, "R3 window top");
    send(32'h0002_0000, 1'b0, 1'b0, "R3 R2 just above window");
    send(32'h0000_FFFF, 1'b0, 1'b0, "R3 R2 just below window");
    send(32'h0001_0000, 1'b0, 1'b1, "R4 flag mismatch misses");

    // R4: slot 1 catches special cycles at low addresses, dest 5
    wr_desc(1, {3'd5, 1'b1, 20'h0, 20'h00000, 20'hFFFFF});
    send(32'h0000_0000, 1'b1, 1'b1, "R4 shutdown special cycle");
    send(32'h0000_0001, 1'b1, 1'b1, "R4 halt special cycle");
    send(32'h0000_0002, 1'b1, 1'b1, "R4 arch-specific special cycle");
    send(32'h0000_0002, 1'b1, 1'b0, "R4 same address without flag");

    // R6: slot 2 range 0x0004_0000.., writes chunks 4-7, reads chunks 8-11, dest 1
    wr_desc(2, {3'd1, 13'h0, 16'h00F0, 16'h0F00, 2'b0, 14'h0001});
    send(32'h0005_0000, 1'b1, 1'b0, "R6 write enabled chunk");
    send(32'h0005_0000, 1'b0, 1'b0, "R6 read disabled chunk");
    send(32'h0006_0010, 1'b0, 1'b0, "R6 read enabled chunk");
    send(32'h0006_0010, 1'b1, 1'b0, "R6 write disabled chunk");
    send(32'h0008_0000, 1'b1, 1'b0, "R6 outside range");

    // R7: slot 3 overlaps slot 2, writes everywhere, dest 6
    wr_desc(3, {3'd6, 13'h0, 16'hFFFF, 16'h0000, 2'b0, 14'h0001});
    send(32'h0004_0000, 1'b1, 1'b0, "R7 only slot 3 matches");
    send(32'h0005_4000, 1'b1, 1'b0, "R7 overlap lowest wins multi");
    send(32'h0006_0000, 1'b0, 1'b0, "R7 read only slot 2");
    chk_idle("R9 idle after burst");

    // R9: rewrite takes effect on next request
    wr_desc(0, {3'd3, 1'b0, 20'h0, 20'h00010, 20'hFFFF0});
    send(32'h0001_0100, 1'b0, 1'b0, "R9 R5 rewritten dest");

    // Random phase
    for (int v = 0; v < 600; v++) begin
      logic [31:0] a;
      logic w, s;
      int k;
      if (v % 60 == 0) begin
        int slot;
        slot = $urandom % 4;
        if (slot < 2) begin
          logic [19:0] m;
          m = 20'hFFFFF << ($urandom % 8);
          wr_desc(slot, {3'($urandom), 1'($urandom), 20'($urandom), 20'($urandom) & m, m});
        end else begin
          wr_desc(slot, {3'($urandom), 13'($urandom), 16'($urandom), 16'($urandom),
                         2'($urandom), 14'($urandom % 4)});
        end
      end
      k = $urandom % 5;
      w = 1'($urandom);
      s = 1'($urandom);
      if (k < 2) begin
        a = $urandom;
        a[31:12] = mdl[k][39:20] | (20'($urandom) & ~mdl[k][19:0]);
        if (($urandom % 4) != 0) s = mdl[k][60];
      end else if (k < 4) begin
        a = $urandom;
        a[31:18] = mdl[k][13:0];
      end else begin
        a = $urandom;
      end
      send(a, w, s, "R7 R3 R6 random vector");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule